// File: doc/BRIEF.md
# Gradient-Descent Spare Line Allocator

This block chooses which faulty rows and columns of a memory array are to be swapped for spares. It models every candidate row and every candidate column as a binary threshold unit. A unit at 1 keeps its line. A unit at 0 marks its line for replacement. Row units form one class and column units form another. A captured fault map couples the two classes. Same-class units are coupled through a penalty weight per class. This penalty pushes the solver toward using spares from both classes in balance.

When a start pulse arrives, the block captures the fault map, the coupling constants and the spare budgets, and sets every unit to 1. On each later cycle it computes every unit's field and push in parallel. It then flips the one unit whose push is largest. When no unit has a positive push, the selection is stable. The block then raises done and reports whether the number of cleared rows and columns fits the spare budgets. The surrounding logic compacts faults into the map beforehand and steers the repair afterwards.

Top module: `sparealloc_net`

## Requirements
- R1: After reset, sel_o is all ones, done_o is 0 and feasible_o is 0.
- R2: A start pulse while idle or done captures flt_i, the weights and the spare budgets, and sets sel_o to all ones with done_o low. Bit r*M2+c of flt_i marks a fault at row r, column c. sel_o bits 0..M1-1 are rows and bits M1..M1+M2-1 are columns. Inputs that change after the capture edge have no effect on the run.
- R3: The field of a row unit is Bw*(2*M1-1) - 2*Bw*(other row units at 1) - 2*A*(faulty columns of that row whose unit is at 1). Bw is the row weight. Column units use the same formula with the column weight and M2. The push is the field when the field is positive and the unit is 0. It is minus the field when the field is negative and the unit is 1. Otherwise it is 0.
- R4: Each step flips exactly one unit: the one with the largest push, with the lowest index winning a tie.
- R5: When the largest push is 0, done_o rises and sel_o holds unchanged until the next start.
- R6: At done, every captured fault has its row or its column at 0.
- R7: At done, no cleared unit of a class with a nonzero weight can be set back to 1 without leaving a fault uncovered.
- R8: A run of k steps raises done_o exactly k+1 clock edges after the capture edge. Here k is at most N+|U|-1, where U is the set of units whose class weight is nonzero.
- R9: At done, feasible_o is 1 exactly when the cleared rows are no more than the row budget and the cleared columns are no more than the column budget.
- R10: A start pulse while a run is in progress is ignored.
- R11: With equal class weights, the first step clears a line that holds the largest number of faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture inputs and begin a run |
| flt_i | input | M1*M2 | Fault map, bit r*M2+c |
| wa_i | input | CW | Cross-class coupling constant A |
| wb_row_i | input | CW | Row class penalty weight |
| wb_col_i | input | CW | Column class penalty weight |
| spare_row_i | input | KW | Available spare rows |
| spare_col_i | input | KW | Available spare columns |
| sel_o | output | M1+M2 | Unit states, 0 = replace that line |
| done_o | output | 1 | Network stable |
| feasible_o | output | 1 | Solution fits the spare budgets |

## Verification
Two pairs of actions can fall in the same cycle. A new start request can land while a step is being taken. Input capture can also coincide with the map changing right after it. Both are provoked on purpose. The bench pulses start with a different map one cycle into a run, and it scrambles every input on the cycle after each capture. It judges the result by whether the final selection and the cycle count match the model for the captured pattern alone. Every fault pattern of a 3x3 array is swept under three weight settings, and each result is compared against an arithmetic model of the descent.

// File: rtl/sa_pkg.sv
package sa_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} sa_state_e;
endpackage

// File: rtl/sa_unit_eval.sv
module sa_unit_eval #(
  parameter int CW      = 8,
  parameter int KW      = 4,
  parameter int FW      = 16,
  parameter int M_CLASS = 4
) (
  input  logic          self_s_i,
  input  logic [KW-1:0] class_ones_i,
  input  logic [KW-1:0] adj_ones_i,
  input  logic [CW-1:0] wa_i,
  input  logic [CW-1:0] wb_i,
  output logic [FW-1:0] push_o
);
  localparam logic signed [FW-1:0] BIAS_K = FW'(2*M_CLASS-1);

  logic [KW-1:0]        others;
  logic signed [FW-1:0] ax, bx, ox, dx, fld;

  assign others = class_ones_i - KW'(self_s_i);
  assign ax  = $signed({{(FW-CW){1'b0}}, wa_i});
  assign bx  = $signed({{(FW-CW){1'b0}}, wb_i});
  assign ox  = $signed({{(FW-KW){1'b0}}, others});
  assign dx  = $signed({{(FW-KW){1'b0}}, adj_ones_i});
  assign fld = bx*BIAS_K - ((bx*ox) <<< 1) - ((ax*dx) <<< 1);

  always_comb begin
    if (fld > 0 && !self_s_i)     push_o = $unsigned(fld);
    else if (fld < 0 && self_s_i) push_o = $unsigned(-fld);
    else                          push_o = '0;
  end
endmodule

// File: rtl/sa_pick_max.sv
module sa_pick_max #(
  parameter int N  = 8,
  parameter int W  = 16,
  parameter int IW = 3
) (
  input  logic [N-1:0][W-1:0] push_i,
  output logic [W-1:0]        max_o,
  output logic [IW-1:0]       idx_o
);
  // strict compare keeps the lowest index on ties
  always_comb begin
    max_o = '0;
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (push_i[i] > max_o) begin
        max_o = push_i[i];
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/sparealloc_net.sv
module sparealloc_net
  import sa_pkg::*;
#(
  parameter int M1 = 4,
  parameter int M2 = 4,
  parameter int CW = 8,
  localparam int N  = M1 + M2,
  localparam int KW = $clog2(N+1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [M1*M2-1:0]   flt_i,
  input  logic [CW-1:0]      wa_i,
  input  logic [CW-1:0]      wb_row_i,
  input  logic [CW-1:0]      wb_col_i,
  input  logic [KW-1:0]      spare_row_i,
  input  logic [KW-1:0]      spare_col_i,
  output logic [N-1:0]       sel_o,
  output logic               done_o,
  output logic               feasible_o
);
  localparam int IW       = $clog2(N);
  localparam int FW       = CW + $clog2(N) + 4;
  localparam int STEP_MAX = 2*N - 1;
  localparam int SW       = $clog2(2*N+1);

  sa_state_e            st_q;
  logic [N-1:0]         s_q;
  logic [M1*M2-1:0]     flt_q;
  logic [CW-1:0]        a_q, b1_q, b2_q;
  logic [KW-1:0]        spr_q, spc_q;
  logic                 feas_q;
  logic [SW-1:0]        steps_q;

  logic [KW-1:0]        row_ones, col_ones, row_zeros, col_zeros;
  logic [N-1:0][KW-1:0] adj;
  logic [N-1:0][FW-1:0] push;
  logic [FW-1:0]        max_push;
  logic [IW-1:0]        idx;
  logic                 uncovered;

  always_comb begin
    row_ones  = '0;
    col_ones  = '0;
    uncovered = 1'b0;
    for (int r = 0; r < M1; r++) row_ones = row_ones + KW'(s_q[r]);
    for (int c = 0; c < M2; c++) col_ones = col_ones + KW'(s_q[M1+c]);
    for (int r = 0; r < M1; r++) begin
      adj[r] = '0;
      for (int c = 0; c < M2; c++)
        adj[r] = adj[r] + KW'(flt_q[r*M2+c] & s_q[M1+c]);
    end
    for (int c = 0; c < M2; c++) begin
      adj[M1+c] = '0;
      for (int r = 0; r < M1; r++)
        adj[M1+c] = adj[M1+c] + KW'(flt_q[r*M2+c] & s_q[r]);
    end
    for (int r = 0; r < M1; r++)
      for (int c = 0; c < M2; c++)
        if (flt_q[r*M2+c] && s_q[r] && s_q[M1+c]) uncovered = 1'b1;
  end

  assign row_zeros = KW'(M1) - row_ones;
  assign col_zeros = KW'(M2) - col_ones;

  for (genvar g = 0; g < M1; g++) begin : g_row
    sa_unit_eval #(.CW(CW), .KW(KW), .FW(FW), .M_CLASS(M1)) u_eval (
      .self_s_i    (s_q[g]),
      .class_ones_i(row_ones),
      .adj_ones_i  (adj[g]),
      .wa_i        (a_q),
      .wb_i        (b1_q),
      .push_o      (push[g])
    );
  end

  for (genvar g = 0; g < M2; g++) begin : g_col
    sa_unit_eval #(.CW(CW), .KW(KW), .FW(FW), .M_CLASS(M2)) u_eval (
      .self_s_i    (s_q[M1+g]),
      .class_ones_i(col_ones),
      .adj_ones_i  (adj[M1+g]),
      .wa_i        (a_q),
      .wb_i        (b2_q),
      .push_o      (push[M1+g])
    );
  end

  sa_pick_max #(.N(N), .W(FW), .IW(IW)) u_pick (
    .push_i(push),
    .max_o (max_push),
    .idx_o (idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      s_q     <= '1;
      flt_q   <= '0;
      a_q     <= '0;
      b1_q    <= '0;
      b2_q    <= '0;
      spr_q   <= '0;
      spc_q   <= '0;
      feas_q  <= 1'b0;
      steps_q <= '0;
    end else begin
      case (st_q)
        ST_RUN: begin
          if (max_push == '0) begin
            st_q   <= ST_DONE;
            feas_q <= (row_zeros <= spr_q) && (col_zeros <= spc_q);
          end else begin
            s_q[idx] <= ~s_q[idx];
            steps_q  <= steps_q + 1'b1;
          end
        end
        default: begin
          if (start_i) begin
            st_q    <= ST_RUN;
            s_q     <= '1;
            flt_q   <= flt_i;
            a_q     <= wa_i;
            b1_q    <= wb_row_i;
            b2_q    <= wb_col_i;
            spr_q   <= spare_row_i;
            spc_q   <= spare_col_i;
            feas_q  <= 1'b0;
            steps_q <= '0;
          end
        end
      endcase
    end
  end

  assign sel_o      = s_q;
  assign done_o     = (st_q == ST_DONE);
  assign feasible_o = feas_q;

  assert_single_flip_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && $past(st_q) == ST_RUN) |-> ($countones(s_q ^ $past(s_q)) <= 1));

  assert_hold_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(done_o)) |-> $stable(sel_o));

  assert_all_covered_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !uncovered);

  assert_step_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    steps_q <= SW'(STEP_MAX));

  assert_run_moves_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && max_push != '0) |=> (s_q != $past(s_q)));
endmodule

// File: tb/sparealloc_net_tb.sv
module sparealloc_net_tb;
  localparam int M1 = 3;
  localparam int M2 = 3;
  localparam int N  = M1 + M2;
  localparam int KW = $clog2(N+1);
  localparam int CW = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start;
  logic [M1*M2-1:0] flt;
  logic [CW-1:0]    wa, wbr, wbc;
  logic [KW-1:0]    spr, spc;
  logic [N-1:0]     sel;
  logic             done, feas;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  sparealloc_net #(.M1(M1), .M2(M2), .CW(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .flt_i(flt),
    .wa_i(wa), .wb_row_i(wbr), .wb_col_i(wbc),
    .spare_row_i(spr), .spare_col_i(spc),
    .sel_o(sel), .done_o(done), .feasible_o(feas)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model(input logic [M1*M2-1:0] f, input int a, input int b1, input int b2,
                       output logic [N-1:0] sf, output logic [N-1:0] s1, output int steps);
    logic [N-1:0] s;
    s = '1; s1 = '1; steps = 0;
    for (int it = 0; it < 64; it++) begin
      int best, bi;
      best = 0; bi = 0;
      for (int i = 0; i < N; i++) begin
        int ones, adjc, b, fv, gv, m;
        ones = 0; adjc = 0;
        if (i < M1) begin
          for (int k = 0; k < M1; k++) ones += int'(s[k]);
          for (int c = 0; c < M2; c++) adjc += int'(f[i*M2+c] & s[M1+c]);
          b = b1; m = M1;
        end else begin
          for (int k = 0; k < M2; k++) ones += int'(s[M1+k]);
          for (int r = 0; r < M1; r++) adjc += int'(f[r*M2+(i-M1)] & s[r]);
          b = b2; m = M2;
        end
        fv = b*(2*m-1) - 2*b*(ones - int'(s[i])) - 2*a*adjc;
        if (fv > 0 && s[i] == 1'b0)      gv = fv;
        else if (fv < 0 && s[i] == 1'b1) gv = -fv;
        else                             gv = 0;
        if (gv > best) begin best = gv; bi = i; end
      end
      if (best == 0) break;
      s[bi] = ~s[bi];
      steps++;
      if (steps == 1) s1 = s;
    end
    sf = s;
  endtask

  function automatic int line_faults(input logic [M1*M2-1:0] f, input int j);
    int n;
    n = 0;
    if (j < M1) for (int c = 0; c < M2; c++) n += int'(f[j*M2+c]);
    else        for (int r = 0; r < M1; r++) n += int'(f[r*M2+(j-M1)]);
    return n;
  endfunction

  function automatic int n_uncov(input logic [M1*M2-1:0] f, input logic [N-1:0] s);
    int n;
    n = 0;
    for (int r = 0; r < M1; r++)
      for (int c = 0; c < M2; c++)
        if (f[r*M2+c] && s[r] && s[M1+c]) n++;
    return n;
  endfunction

  task automatic run_one(input logic [M1*M2-1:0] f, input int a, input int b1, input int b2,
                         input int sr, input int sc, input bit chk_max);
    logic [N-1:0] sf, s1;
    int steps, n, ucnt, zr, zc, mx;
    model(f, a, b1, b2, sf, s1, steps);
    ucnt = M1 + ((b2 > 0) ? M2 : 0);
    @(negedge clk);
    flt = f; wa = CW'(a); wbr = CW'(b1); wbc = CW'(b2);
    spr = KW'(sr); spc = KW'(sc); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    flt = ~f; wa = '0; wbr = 8'hff; wbc = 8'hff; spr = '0; spc = '0;  // ignored after capture (R2)
    check(sel == '1 && !done, "R2 load", int'(sel), (1 << N) - 1);
    n = 0;
    while (1) begin
      @(negedge clk);
      n++;
      if (n == 1 && steps >= 1) begin
        check(sel == s1, "R4 first step", int'(sel), int'(s1));
        if (chk_max) begin
          mx = 0;
          for (int j = 0; j < N; j++) if (line_faults(f, j) > mx) mx = line_faults(f, j);
          for (int j = 0; j < N; j++)
            if (!sel[j]) check(line_faults(f, j) == mx, "R11 heaviest line", line_faults(f, j), mx);
        end
      end
      if (done || n > 40) break;
    end
    check(n == steps + 1, "R8 done timing", n, steps + 1);
    check(steps <= N + ucnt - 1, "R8 step bound", steps, N + ucnt - 1);
    check(sel == sf, "R3 final selection", int'(sel), int'(sf));
    check(n_uncov(f, sel) == 0, "R6 cover", n_uncov(f, sel), 0);
    for (int i = 0; i < N; i++) begin
      if (!sel[i] && (i < M1 || b2 > 0)) begin
        logic [N-1:0] t;
        t = sel; t[i] = 1'b1;
        check(n_uncov(f, t) > 0, "R7 minimal", n_uncov(f, t), 1);
      end
    end
    zr = 0; zc = 0;
    for (int i = 0; i < M1; i++) zr += int'(!sel[i]);
    for (int i = 0; i < M2; i++) zc += int'(!sel[M1+i]);
    check(feas == ((zr <= sr) && (zc <= sc)), "R9 feasible", int'(feas), int'((zr <= sr) && (zc <= sc)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [N-1:0] sf, s1, held;
    int steps, n;
    rst_n = 1'b0; start = 1'b0; flt = '0; wa = '0; wbr = '0; wbc = '0; spr = '0; spc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(sel == '1, "R1 reset sel", int'(sel), (1 << N) - 1);
    check(!done && !feas, "R1 reset flags", int'({done, feas}), 0);

    // R10: start pulse mid-run with another pattern is ignored
    model(9'h1ff, 6, 1, 1, sf, s1, steps);
    @(negedge clk);
    flt = 9'h1ff; wa = 8'd6; wbr = 8'd1; wbc = 8'd1; spr = 3'd3; spc = 3'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    flt = 9'h001; spr = 3'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 40) begin @(negedge clk); n++; end
    check(sel == sf, "R10 start ignored while running", int'(sel), int'(sf));
    check(feas == 1'b1, "R10 budgets kept", int'(feas), 1);
    held = sel;
    repeat (3) @(negedge clk);
    check(done && sel == held, "R5 hold after done", int'(sel), int'(held));

    for (int p = 0; p < 512; p++) run_one(9'(p), 6, 1, 1, p % 4, (p / 4) % 4, 1'b1);
    for (int p = 0; p < 512; p++) run_one(9'(p), 11, 2, 1, 2, 1, 1'b0);
    for (int p = 0; p < 512; p++) run_one(9'(p), 6, 1, 0, 3, 3, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule